// File: doc/BRIEF.md
# Prefix Real-to-Absolute Address Mapper

This block sits after address translation. It turns a real address into an absolute address by exchanging two 8 KB windows. The first window is the bottom of the address space. The second is a movable window that starts at a programmable prefix base. An address inside either window is sent to the matching location in the other window. Every other address passes straight through. The result is registered and appears one cycle after the request.

With each mapped access the block also records which pages have been used. It keeps a small key store with one entry per 4 KB page, and each entry holds two bits. The reference bit is set when the access was granted read permission. The change bit is set when write permission was granted. A key is updated only when the absolute address lies within the configured memory limit. The block drives the key update on an outgoing write port. A debug port reads any key entry at any time.

Top module: `pfxmap_top`

## Requirements
- R1: A real address below 0x2000 yields the absolute address real + prefix (modulo 2^ADDR_W).
- R2: A real address at or above the prefix base and below prefix base + 0x2000 yields real − prefix.
- R3: Any other real address yields an absolute address equal to the real address.
- R4: The low 13 bits of the prefix base input are ignored, so 0x4A5C3 behaves exactly like 0x4A000.
- R5: The low-window match takes priority, so at most one window is ever selected for a request.
- R6: absValid is high exactly in the cycle after a cycle with reqValid high, and absAddr holds that request's result.
- R7: A key update is issued, in the same cycle as absValid, only when absAddr ≤ memLimit. Otherwise keyWrEn stays low and no key changes.
- R8: The key index is absAddr >> 12. keyWrBits bit 0 is the reference bit and equals the read grant. Bit 1 is the change bit and equals the write grant.
- R9: Key bits are only ever ORed in. An update never clears a bit that is already set. The store is written on the clock edge that follows the update cycle.
- R10: Reset clears every key entry to 0. dbgKey combinationally returns the entry selected by dbgIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| realAddr | input | ADDR_W | Real address |
| prefixBase | input | ADDR_W | Prefix base. The low 13 bits are ignored |
| grantRead | input | 1 | Read permission was granted |
| grantWrite | input | 1 | Write permission was granted |
| memLimit | input | ADDR_W | Highest absolute address that owns a key |
| absValid | output | 1 | Result valid, one cycle after the request |
| absAddr | output | ADDR_W | Absolute address |
| keyWrEn | output | 1 | Key update strobe |
| keyWrIdx | output | ADDR_W-12 | Page index of the key update |
| keyWrBits | output | 2 | Bits to OR in: bit 1 change, bit 0 reference |
| dbgIdx | input | ADDR_W-12 | Debug key read index |
| dbgKey | output | 2 | Debug key read data |

## Verification
The assertions assume that prefixBase, memLimit and the grant flags stay stable from the request cycle until the result cycle. They also assume that dbgIdx is held steady while the monotonic-key property is observed. The bench drives every request on a falling edge and holds all inputs for the whole request and result cycles. It then idles for one cycle before the next request, so the key write has landed before anything is read back. The bench sweeps every page under several prefixes, including an unaligned prefix, and under two memory limits. The second limit falls exactly on a page address, so the boundary page is covered.

// File: rtl/pfxmap_pkg.sv
package pfxmap_pkg;
  typedef struct packed {
    logic load;
    logic winLow;
    logic winHigh;
    logic keyWe;
    logic setRef;
    logic setChg;
  } mapStrobes_t;
endpackage

// File: rtl/pfxmap_ctrl.sv
module pfxmap_ctrl
  import pfxmap_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int WIN_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] realAddr,
  input  logic [ADDR_W-1:0] prefixBase,
  input  logic              grantRead,
  input  logic              grantWrite,
  input  logic [ADDR_W-1:0] memLimit,
  input  logic [ADDR_W-1:0] absAddr,
  output logic              absValid,
  output mapStrobes_t       strobes
);
  localparam logic [ADDR_W:0] WIN_SIZE = {{ADDR_W{1'b0}}, 1'b1} << WIN_SHIFT;

  logic [ADDR_W-1:0] prefAligned;
  logic [ADDR_W:0]   prefEnd;
  logic              inLow;
  logic              inHigh;
  logic              stageValid;
  logic              stageRd;
  logic              stageWr;

  assign prefAligned = {prefixBase[ADDR_W-1:WIN_SHIFT], {WIN_SHIFT{1'b0}}};
  assign prefEnd     = {1'b0, prefAligned} + WIN_SIZE;
  assign inLow       = (realAddr[ADDR_W-1:WIN_SHIFT] == '0);
  assign inHigh      = !inLow && (realAddr >= prefAligned) &&
                       ({1'b0, realAddr} < prefEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageRd    <= 1'b0;
      stageWr    <= 1'b0;
    end else begin
      stageValid <= reqValid;
      if (reqValid) begin
        stageRd <= grantRead;
        stageWr <= grantWrite;
      end
    end
  end

  always_comb begin
    strobes.load    = reqValid;
    strobes.winLow  = reqValid && inLow;
    strobes.winHigh = reqValid && inHigh;
    strobes.keyWe   = stageValid && (absAddr <= memLimit);
    strobes.setRef  = stageRd;
    strobes.setChg  = stageWr;
  end

  assign absValid = stageValid;

  AST_WIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.winLow, strobes.winHigh})); // R5
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> absValid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !absValid); // R6
endmodule

// File: rtl/pfxmap_dp.sv
module pfxmap_dp
  import pfxmap_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int WIN_SHIFT  = 13,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT,
  localparam int PAGES     = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobes_t       strobes,
  input  logic [ADDR_W-1:0] realAddr,
  input  logic [ADDR_W-1:0] prefixBase,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [ADDR_W-1:0] absAddr,
  output logic              keyWrEn,
  output logic [IDX_W-1:0]  keyWrIdx,
  output logic [1:0]        keyWrBits,
  output logic [1:0]        dbgKey
);
  logic [ADDR_W-1:0] prefAligned;
  logic [ADDR_W-1:0] nextAbs;
  logic [1:0]        keyRam [PAGES];

  assign prefAligned = {prefixBase[ADDR_W-1:WIN_SHIFT], {WIN_SHIFT{1'b0}}};

  always_comb begin
    if (strobes.winLow)       nextAbs = realAddr + prefAligned;
    else if (strobes.winHigh) nextAbs = realAddr - prefAligned;
    else                      nextAbs = realAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             absAddr <= '0;
    else if (strobes.load) absAddr <= nextAbs;
  end

  assign keyWrEn   = strobes.keyWe;
  assign keyWrIdx  = absAddr[ADDR_W-1:PAGE_SHIFT];
  assign keyWrBits = {strobes.setChg, strobes.setRef};

  for (genvar g = 0; g < PAGES; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rstN)
        keyRam[g] <= 2'b00;
      else if (keyWrEn && (keyWrIdx == IDX_W'(g)))
        keyRam[g] <= keyRam[g] | keyWrBits;
    end
  end

  assign dbgKey = keyRam[dbgIdx];

  AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.winLow |=> absAddr == $past(realAddr) + $past(prefAligned)); // R1
  AST_KEY_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    $stable(dbgIdx) |-> ((dbgKey & $past(dbgKey)) == $past(dbgKey))); // R9
endmodule

// File: rtl/pfxmap_top.sv
module pfxmap_top
  import pfxmap_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int WIN_SHIFT  = 13,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] realAddr,
  input  logic [ADDR_W-1:0] prefixBase,
  input  logic              grantRead,
  input  logic              grantWrite,
  input  logic [ADDR_W-1:0] memLimit,
  output logic              absValid,
  output logic [ADDR_W-1:0] absAddr,
  output logic              keyWrEn,
  output logic [IDX_W-1:0]  keyWrIdx,
  output logic [1:0]        keyWrBits,
  input  logic [IDX_W-1:0]  dbgIdx,
  output logic [1:0]        dbgKey
);
  mapStrobes_t strobes;

  pfxmap_ctrl #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .realAddr(realAddr),
    .prefixBase(prefixBase), .grantRead(grantRead), .grantWrite(grantWrite),
    .memLimit(memLimit), .absAddr(absAddr), .absValid(absValid),
    .strobes(strobes)
  );

  pfxmap_dp #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .WIN_SHIFT(WIN_SHIFT)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .realAddr(realAddr),
    .prefixBase(prefixBase), .dbgIdx(dbgIdx), .absAddr(absAddr),
    .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx), .keyWrBits(keyWrBits),
    .dbgKey(dbgKey)
  );
endmodule

// File: tb/test_pfxmap_top.sv
`timescale 1ns/1ps
module test_pfxmap_top;
  localparam int AW = 20;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] realAddr = '0, prefixBase = '0, memLimit = '1;
  logic grantRead = 1'b0, grantWrite = 1'b0;
  logic absValid, keyWrEn;
  logic [AW-1:0] absAddr;
  logic [IW-1:0] keyWrIdx;
  logic [IW-1:0] dbgIdx = '0;
  logic [1:0] keyWrBits, dbgKey;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [1:0] model [256];

  always #10 clk = ~clk;

  pfxmap_top i_pfxmap_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .realAddr(realAddr),
    .prefixBase(prefixBase), .grantRead(grantRead), .grantWrite(grantWrite),
    .memLimit(memLimit), .absValid(absValid), .absAddr(absAddr),
    .keyWrEn(keyWrEn), .keyWrIdx(keyWrIdx), .keyWrBits(keyWrBits),
    .dbgIdx(dbgIdx), .dbgKey(dbgKey)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 256; i++) model[i] = 2'b00;
  endtask

  task automatic dumpKeys(string tag);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      dbgIdx = IW'(i);
      #1;
      check(tag, 32'(dbgKey), 32'(model[i]));
    end
  endtask

  task automatic doReq(logic [AW-1:0] ra, logic [AW-1:0] pb, bit rd, bit wr, string tagOvr);
    logic [AW-1:0] pa, expAbs;
    string tag;
    bit expWe;
    pa = {pb[AW-1:13], 13'b0};
    if (ra < 20'h2000) begin
      expAbs = ra + pa; tag = "R1";
    end else if (ra >= pa && {1'b0, ra} < {1'b0, pa} + 21'h2000) begin
      expAbs = ra - pa; tag = "R2";
    end else begin
      expAbs = ra; tag = "R3";
    end
    if (tagOvr != "") tag = tagOvr;
    @(negedge clk);
    realAddr = ra; prefixBase = pb; grantRead = rd; grantWrite = wr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R6 valid", 32'(absValid), 32'd1);
    check(tag, 32'(absAddr), 32'(expAbs));
    expWe = (expAbs <= memLimit);
    check("R7 keyWrEn", 32'(keyWrEn), 32'(expWe));
    if (expWe) begin
      check("R8 index", 32'(keyWrIdx), 32'(expAbs[AW-1:12]));
      check("R8 bits", 32'(keyWrBits), {30'b0, wr, rd});
      model[expAbs[AW-1:12]] = model[expAbs[AW-1:12]] | {wr, rd};
    end
    @(negedge clk);
    check("R6 idle", 32'(absValid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] prefs [5];
    prefs[0] = 20'h00000; prefs[1] = 20'h02000; prefs[2] = 20'h36000;
    prefs[3] = 20'hFE000; prefs[4] = 20'h4A5C3;
    doReset();
    dumpKeys("R10 reset");
    memLimit = 20'hFFFFF;
    for (int q = 0; q < 5; q++) begin
      for (int p = 0; p < 256; p++) begin
        logic [AW-1:0] ra;
        ra = (AW'(p) << 12) | AW'((p * 37 + q * 11) & 12'hFFF);
        doReq(ra, prefs[q], p[0], p[1] ^ q[0], (q == 4) ? "R4" : "");
      end
      doReq(20'h0, prefs[q], 1'b0, 1'b0, "R5");
    end
    dumpKeys("R9 or-only");
    doReset();
    dumpKeys("R10 cleared");
    memLimit = 20'h80000;
    for (int p = 0; p < 256; p++)
      doReq(AW'(p) << 12, 20'h10000, 1'b1, p[0], "");
    dumpKeys("R7 limit");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule